// File: doc/BRIEF.md
# Bitwise Priority ID Bus Arbiter

Each node that shares a wired-OR bus line has one copy of this engine. Every node owns a unique numeric ID, and that ID is its priority. When the current transfer on the bus has ended, a one-cycle `start_i` pulse arrives at all nodes together. Each node that has `req_i` high at that pulse captures its ID. It then places the ID on the line one bit per clock, starting with the most significant bit.

During each slot the node compares the bit it drives with the level it senses on the line. A 1 on the line dominates a 0. A node that drives 0 while the line reads 1 has met a higher ID: it stops driving and pulses `lost_o`. If the node gets through the last bit without such a conflict, it pulses `grant_o`. The node with the highest requesting ID therefore always wins, in a fixed number of cycles. A node with a lower ID wins only when no higher node is requesting.

A node that loses keeps its request pending. It joins the contest again at the next `start_i` pulse.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset, `bus_drive_o`, `grant_o` and `lost_o` are all 0.
- R2: A contest begins only at a clock edge where both `start_i` and `req_i` are 1. With either one low, the node does not drive the line and produces no pulse.
- R3: Let the contest begin at edge E. In the cycle after edge E+k, `bus_drive_o` carries bit ID_W-1-k of the ID captured at E, for k = 0 to ID_W-1. The bits therefore go out most significant first.
- R4: If the node drives 0 while `bus_sense_i` is 1 at a sampling edge, `lost_o` is 1 for exactly the next cycle. From that cycle on, `bus_drive_o` stays 0 until a new contest begins.
- R5: A node that meets no conflict on any of its ID_W bits pulses `grant_o` for exactly one cycle, starting at edge E+ID_W. `grant_o` and `lost_o` are never 1 together.
- R6: A node requesting alone always receives the grant, whatever its ID.
- R7: A node that lost and still holds `req_i` high competes again at the next `start_i` pulse, and wins if no higher ID requests.
- R8: A `start_i` pulse that arrives while a contest is in progress has no effect on that contest.
- R9: Driving 1 while sensing 1, or driving 0 while sensing 0, is not a conflict.
- R10: Among several requesters, the highest ID wins. Every other requester loses at the first bit, counted from the MSB, where its ID differs from the highest one. Its `lost_o` appears one cycle after that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Node wants the bus |
| start_i | input | 1 | One-cycle pulse: previous transfer finished, arbitration may begin |
| id_i | input | ID_W | Unique priority ID of this node; higher value wins |
| bus_drive_o | output | 1 | Level this node places on the wired-OR line (1 dominant) |
| bus_sense_i | input | 1 | Level read back from the wired-OR line |
| grant_o | output | 1 | One-cycle pulse: arbitration won |
| lost_o | output | 1 | One-cycle pulse: arbitration lost |

## Verification
A loss and a grant can fall in the same cycle. This happens on different nodes whose IDs differ only in the least significant bit, so the loser finds its conflict on the final slot, the same slot that completes the winner. The bench provokes this with IDs 6 and 7. It judges that the node with ID 6 sees only `lost_o`, the node with ID 7 sees only `grant_o`, and both pulses arrive in the same cycle, ID_W+1 cycles after the start pulse was driven. Each round's expected events are queued in time order and compared, one by one, against what the three nodes produce.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            start_i,
  input  logic [ID_W-1:0] id_i,
  output logic            bus_drive_o,
  input  logic            bus_sense_i,
  output logic            grant_o,
  output logic            lost_o
);
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ID_W - 1);

  logic            busy;
  logic [IDX_W-1:0] bit_idx;
  logic [ID_W-1:0] id_q;
  logic            conflict;
  logic            last_bit;

  assign bus_drive_o = busy & id_q[bit_idx];
  assign conflict    = busy & ~bus_drive_o & bus_sense_i;
  assign last_bit    = (bit_idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bit_idx <= '0;
      id_q    <= '0;
      grant_o <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      grant_o <= 1'b0;
      lost_o  <= 1'b0;
      if (!busy) begin
        if (start_i && req_i) begin
          busy    <= 1'b1;
          bit_idx <= TOP_IDX;
          id_q    <= id_i;
        end
      end else if (conflict) begin
        busy   <= 1'b0;
        lost_o <= 1'b1;
      end else if (last_bit) begin
        busy    <= 1'b0;
        grant_o <= 1'b1;
      end else begin
        bit_idx <= bit_idx - 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic bus_drive_o,
  input logic bus_sense_i,
  input logic grant_o,
  input logic lost_o
);
  p_drive_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_drive_o |-> busy);

  p_lost_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> $past(!bus_drive_o && bus_sense_i));

  p_quiet_after_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> (!bus_drive_o && !busy));

  p_grant_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> !grant_o);

  p_lost_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |=> !lost_o);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_o && lost_o));

  p_grant_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> $past(busy && !(!bus_drive_o && bus_sense_i)));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .bus_drive_o(bus_drive_o),
  .bus_sense_i(bus_sense_i), .grant_o(grant_o), .lost_o(lost_o)
);

// File: tb/sim_prio_bus_arbiter.sv
`timescale 1ns/1ps
module sim_prio_bus_arbiter;
  localparam int W = 4;
  localparam int N = 3;

  typedef struct {
    int    node;
    bit    gnt;
    int    off;
    string tag;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] req = '0;
  logic [W-1:0] ids [N];
  logic [N-1:0] drv, gnt, lst;
  logic bus;

  ev_t exp_q[$];
  int  checks = 0, fails = 0;
  int  ecnt = 0, st = 0;
  bit  done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;
  assign bus = |drv;

  prio_bus_arbiter #(.ID_W(W)) u0 (.clk(clk), .rst_n(rst_n), .req_i(req[0]), .start_i(start),
    .id_i(ids[0]), .bus_drive_o(drv[0]), .bus_sense_i(bus), .grant_o(gnt[0]), .lost_o(lst[0]));
  prio_bus_arbiter #(.ID_W(W)) u1 (.clk(clk), .rst_n(rst_n), .req_i(req[1]), .start_i(start),
    .id_i(ids[1]), .bus_drive_o(drv[1]), .bus_sense_i(bus), .grant_o(gnt[1]), .lost_o(lst[1]));
  prio_bus_arbiter #(.ID_W(W)) u2 (.clk(clk), .rst_n(rst_n), .req_i(req[2]), .start_i(start),
    .id_i(ids[2]), .bus_drive_o(drv[2]), .bus_sense_i(bus), .grant_o(gnt[2]), .lost_o(lst[2]));

  function automatic void check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  function automatic void observe(int n, bit g);
    ev_t e;
    if (exp_q.size() == 0) begin
      check(0, g ? "R5 unexpected grant" : "R4 unexpected lost", n, -1);
      return;
    end
    e = exp_q.pop_front();
    check(e.node == n && e.gnt == g && e.off == ecnt - st, e.tag,
          n * 1000 + g * 100 + (ecnt - st), e.node * 1000 + e.gnt * 100 + e.off);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < N; n++) begin
        if (gnt[n]) observe(n, 1'b1);
        if (lst[n]) observe(n, 1'b0);
      end
    end
  end

  task automatic round(input logic [N-1:0] mask, input bit extra_start, input string tag);
    int win = -1;
    int lose_k[N];
    ev_t e;
    for (int n = 0; n < N; n++)
      if (mask[n] && (win < 0 || ids[n] > ids[win])) win = n;
    for (int n = 0; n < N; n++) begin
      lose_k[n] = -1;
      if (mask[n]) begin
        lose_k[n] = W;
        if (n != win)
          for (int k = W - 1; k >= 0; k--)
            if (ids[n][W-1-k] != ids[win][W-1-k]) lose_k[n] = k;
      end
    end
    @(posedge clk); #2;
    req = mask;
    start = 1'b1;
    st = ecnt;
    for (int off = 2; off <= W + 1; off++)
      for (int n = 0; n < N; n++) begin
        if (n != win && lose_k[n] == off - 2) begin
          e.node = n; e.gnt = 0; e.off = off; e.tag = {tag, " R10 loss slot"};
          exp_q.push_back(e);
        end
        if (n == win && off == W + 1) begin
          e.node = n; e.gnt = 1; e.off = off; e.tag = {tag, " R5 grant timing"};
          exp_q.push_back(e);
        end
      end
    @(posedge clk); #2;
    start = 1'b0;
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      for (int n = 0; n < N; n++) begin
        logic ed;
        ed = (lose_k[n] >= k) ? ids[n][W-1-k] : 1'b0;
        check(drv[n] == ed, {tag, " R3/R4 drive bit"}, drv[n], ed);
      end
      if (extra_start && k == 1) start = 1'b1;
      if (extra_start && k == 2) start = 1'b0;
    end
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, {tag, " missing events"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    ids[0] = '0; ids[1] = '0; ids[2] = '0;
    repeat (3) @(negedge clk);
    check(drv == '0, "R1 drive after reset", drv, 0);
    check(gnt == '0 && lst == '0, "R1 pulses after reset", {gnt, lst}, 0);
    rst_n = 1'b1;

    req = 3'b111;
    repeat (6) @(negedge clk);
    check(drv == '0, "R2 request without start", drv, 0);

    ids[0] = 4'd10; ids[1] = 4'd9; ids[2] = 4'd3;
    round(3'b010, 0, "R6 lone");
    round(3'b001, 0, "R6 lone R3");
    ids[0] = 4'd12; ids[1] = 4'd5; ids[2] = 4'd3;
    round(3'b111, 0, "R10 three-way");
    ids[0] = 4'd6; ids[1] = 4'd7; ids[2] = 4'd1;
    round(3'b011, 0, "R9 lsb tie-break");
    round(3'b001, 0, "R7 rejoin");
    ids[0] = 4'd13; ids[1] = 4'd14; ids[2] = 4'd15;
    round(3'b111, 1, "R8 restart ignored");
    round(3'b000, 0, "R2 start without request");
    ids[0] = 4'd0; ids[1] = 4'd8; ids[2] = 4'd4;
    round(3'b101, 0, "R7 zero id loses");
    round(3'b001, 0, "R7 zero id rejoins");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule